// File: doc/BRIEF.md
# Bus Error Capture Unit

This block sits beside a bus interface and keeps a record of what went wrong on it. The protocol engine signals each error type as a single-cycle pulse on its own line. In that same cycle it presents the details of the failing transaction: the low and high halves of the address, the data or attribute word, the command word and the parity bits. The unit latches one sticky flag per error type in a cause register. It freezes a copy of the transaction details for the first error seen while no flag is pending. It raises an interrupt when any pending flag is enabled in a mask register.

Software runs the unit through a small write port. The handler reads the cause value from `cause_o` and reads the frozen details from the capture outputs. It then writes the inverted cause value back into the cause register. A zero written to a flag clears it, and a one leaves it alone, so errors that arrive between the read and the write are not lost. When every flag is clear, the capture registers are armed again for the next error. The mask is normally written to zero first and then loaded with its enable pattern, so no interrupt can fire during setup.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, `cause_o`, `cap_addr_lo_o`, `cap_addr_hi_o`, `cap_attr_o`, `cap_cmd_o`, `cap_par_o` and `irq_o` are all zero, and `mask_o` equals `MASK_RST` (default 0).
- R2: A pulse on `err_pulse_i[i]` sets `cause_o[i]` from the next cycle on. The bit stays set until a write with `reg_sel_i`=0 carries a 0 in bit i, which clears it. A 1 in that bit leaves it unchanged.
- R3: If an error pulse on bit i falls in the same cycle as a cause write that has 0 in bit i, `cause_o[i]` is 1 in the next cycle.
- R4: If the pulse has at least one bit inside `IMPL_MASK` and `cause_o` is all zero in that cycle, the five capture outputs show that cycle's transaction fields from the next cycle on.
- R5: While any cause bit is set, the capture outputs keep their values, even when further errors arrive.
- R6: Once every cause bit has been cleared, the next qualifying error loads the capture outputs again.
- R7: A write with `reg_sel_i`=1 replaces `mask_o` with `reg_wdata_i` in the next cycle and does not alter `cause_o`.
- R8: With `IRQ_PIPE`=0 (default), `irq_o` is the OR over all bits of `cause_o & mask_o` in the same cycle. With `IRQ_PIPE`=1, it follows one cycle later.
- R9: Cause bits outside `IMPL_MASK` (default 8'hEF, so bit 4 is absent) always read 0. A pulse only on such bits neither sets a flag nor loads the capture outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse_i | input | NUM_CAUSE | One-cycle error pulses, one line per error type |
| txn_addr_lo_i | input | ADDR_W | Low address word of the current transaction |
| txn_addr_hi_i | input | ADDR_W | High address word of the current transaction |
| txn_attr_i | input | ATTR_W | Data or attribute word of the current transaction |
| txn_cmd_i | input | CMD_W | Command word of the current transaction |
| txn_par_i | input | PAR_W | Parity bits of the current transaction |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 cause (clear where 0), 1 mask |
| reg_wdata_i | input | NUM_CAUSE | Write data |
| cause_o | output | NUM_CAUSE | Sticky error flags |
| mask_o | output | NUM_CAUSE | Interrupt enable mask |
| cap_addr_lo_o | output | ADDR_W | Captured low address |
| cap_addr_hi_o | output | ADDR_W | Captured high address |
| cap_attr_o | output | ATTR_W | Captured data or attribute word |
| cap_cmd_o | output | CMD_W | Captured command |
| cap_par_o | output | PAR_W | Captured parity |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision of interest is a new error pulse landing in the same cycle as the software write that clears its flag. The bench provokes it in a directed step: it pulses bit 1 while writing a cause value with 0 in bit 1. It expects bit 1 to be set afterwards. It also expects the capture outputs to stay frozen, because another flag was still pending in that cycle. A random phase then mixes pulses, clearing writes and mask writes freely. A behavioural model checks cause, mask, captures and interrupt on every cycle, so these collisions are also judged under random timing.

// File: rtl/bec_pkg.sv
package bec_pkg;

   typedef enum logic {
      BEC_SEL_CAUSE = 1'b0,
      BEC_SEL_MASK  = 1'b1
   } bec_sel_e;

endpackage

// File: rtl/bec_cause_reg.sv
module bec_cause_reg #(
   parameter int                   NUM_CAUSE = 8,
   parameter logic [NUM_CAUSE-1:0] IMPL_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CAUSE-1:0] err_i,
   input  logic                 clr_we_i,
   input  logic [NUM_CAUSE-1:0] clr_data_i,
   output logic [NUM_CAUSE-1:0] cause_o,
   output logic                 any_o
);

   logic [NUM_CAUSE-1:0] cause_q;

   for (genvar gi = 0; gi < NUM_CAUSE; gi++) begin : g_bit
      if (IMPL_MASK[gi]) begin : g_impl
         always_ff @(posedge clk) begin
            if (!rst_n)
               cause_q[gi] <= 1'b0;
            else if (err_i[gi])
               cause_q[gi] <= 1'b1;
            else if (clr_we_i && !clr_data_i[gi])
               cause_q[gi] <= 1'b0;
         end

         // R3: a pulse wins over a clearing write in the same cycle
         a_r3_error_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            err_i[gi] |=> cause_o[gi]);

         // R2: a flag only drops through a clearing write
         a_r2_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_o[gi] && !(clr_we_i && !clr_data_i[gi])) |=> cause_o[gi]);
      end else begin : g_absent
         assign cause_q[gi] = 1'b0;
      end
   end

   assign cause_o = cause_q;
   assign any_o   = |cause_q;

   // R9: bits outside the implemented set never rise
   a_r9_absent_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_o & ~IMPL_MASK) == '0);

endmodule

// File: rtl/bec_capture_field.sv
module bec_capture_field #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   initial begin
      assert (W >= 1) else $error("bec_capture_field: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end

   // R4: loaded value is the one presented with the error
   a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (q_o == $past(d_i)));

   // R5: frozen when no load is requested
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));

endmodule

// File: rtl/bec_irq_gate.sv
module bec_irq_gate #(
   parameter int NUM_CAUSE = 8,
   parameter bit IRQ_PIPE  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CAUSE-1:0] cause_i,
   input  logic [NUM_CAUSE-1:0] mask_i,
   output logic                 irq_o
);

   logic hit;
   assign hit = |(cause_i & mask_i);

   if (IRQ_PIPE) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= hit;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = hit;
   end

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
   import bec_pkg::*;
#(
   parameter int                   NUM_CAUSE = 8,
   parameter logic [NUM_CAUSE-1:0] IMPL_MASK = 8'hEF,
   parameter logic [NUM_CAUSE-1:0] MASK_RST  = '0,
   parameter int                   ADDR_W    = 32,
   parameter int                   ATTR_W    = 32,
   parameter int                   CMD_W     = 32,
   parameter int                   PAR_W     = 8,
   parameter bit                   IRQ_PIPE  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CAUSE-1:0] err_pulse_i,
   input  logic [ADDR_W-1:0]    txn_addr_lo_i,
   input  logic [ADDR_W-1:0]    txn_addr_hi_i,
   input  logic [ATTR_W-1:0]    txn_attr_i,
   input  logic [CMD_W-1:0]     txn_cmd_i,
   input  logic [PAR_W-1:0]     txn_par_i,
   input  logic                 reg_we_i,
   input  logic                 reg_sel_i,
   input  logic [NUM_CAUSE-1:0] reg_wdata_i,
   output logic [NUM_CAUSE-1:0] cause_o,
   output logic [NUM_CAUSE-1:0] mask_o,
   output logic [ADDR_W-1:0]    cap_addr_lo_o,
   output logic [ADDR_W-1:0]    cap_addr_hi_o,
   output logic [ATTR_W-1:0]    cap_attr_o,
   output logic [CMD_W-1:0]     cap_cmd_o,
   output logic [PAR_W-1:0]     cap_par_o,
   output logic                 irq_o
);

   initial begin
      assert (NUM_CAUSE >= 1 && NUM_CAUSE <= 32)
         else $error("bus_err_capture: NUM_CAUSE out of range");
      assert (IMPL_MASK != '0)
         else $error("bus_err_capture: no cause bit implemented");
   end

   bec_sel_e             sel;
   logic                 cause_wr;
   logic                 mask_wr;
   logic [NUM_CAUSE-1:0] err_valid;
   logic                 any_pending;
   logic                 cap_load;
   logic [NUM_CAUSE-1:0] mask_q;

   assign sel       = bec_sel_e'(reg_sel_i);
   assign cause_wr  = reg_we_i && (sel == BEC_SEL_CAUSE);
   assign mask_wr   = reg_we_i && (sel == BEC_SEL_MASK);
   assign err_valid = err_pulse_i & IMPL_MASK;
   assign cap_load  = (|err_valid) && !any_pending;

   bec_cause_reg #(
      .NUM_CAUSE (NUM_CAUSE),
      .IMPL_MASK (IMPL_MASK)
   ) cause_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_i      (err_valid),
      .clr_we_i   (cause_wr),
      .clr_data_i (reg_wdata_i),
      .cause_o    (cause_o),
      .any_o      (any_pending)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= MASK_RST;
      else if (mask_wr)
         mask_q <= reg_wdata_i;
   end
   assign mask_o = mask_q;

   // R7: mask writes land one cycle later
   a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_o == $past(reg_wdata_i)));

   bec_capture_field #(.W(ADDR_W)) cap_alo_i (
      .clk(clk), .rst_n(rst_n), .load_i(cap_load), .d_i(txn_addr_lo_i), .q_o(cap_addr_lo_o));
   bec_capture_field #(.W(ADDR_W)) cap_ahi_i (
      .clk(clk), .rst_n(rst_n), .load_i(cap_load), .d_i(txn_addr_hi_i), .q_o(cap_addr_hi_o));
   bec_capture_field #(.W(ATTR_W)) cap_attr_i (
      .clk(clk), .rst_n(rst_n), .load_i(cap_load), .d_i(txn_attr_i), .q_o(cap_attr_o));
   bec_capture_field #(.W(CMD_W)) cap_cmd_i (
      .clk(clk), .rst_n(rst_n), .load_i(cap_load), .d_i(txn_cmd_i), .q_o(cap_cmd_o));
   bec_capture_field #(.W(PAR_W)) cap_par_i (
      .clk(clk), .rst_n(rst_n), .load_i(cap_load), .d_i(txn_par_i), .q_o(cap_par_o));

   // R5: captures never move while a flag is pending
   a_r5_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_o != '0) |=> $stable(cap_addr_lo_o) && $stable(cap_cmd_o));

   bec_irq_gate #(
      .NUM_CAUSE (NUM_CAUSE),
      .IRQ_PIPE  (IRQ_PIPE)
   ) irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause_i (cause_o),
      .mask_i  (mask_q),
      .irq_o   (irq_o)
   );

endmodule

// File: tb/bus_err_capture_tb_top.sv
module bus_err_capture_tb_top;

   localparam int          N    = 8;
   localparam logic [N-1:0] IMPL = 8'hEF;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] err_pulse;
   logic [31:0]  a_lo, a_hi, attr, cmd;
   logic [7:0]   par;
   logic         we, sel;
   logic [N-1:0] wdata;
   logic [N-1:0] cause_o, mask_o;
   logic [31:0]  c_alo, c_ahi, c_attr, c_cmd;
   logic [7:0]   c_par;
   logic         irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   bus_err_capture dut_i (
      .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse),
      .txn_addr_lo_i(a_lo), .txn_addr_hi_i(a_hi), .txn_attr_i(attr),
      .txn_cmd_i(cmd), .txn_par_i(par),
      .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
      .cause_o(cause_o), .mask_o(mask_o),
      .cap_addr_lo_o(c_alo), .cap_addr_hi_o(c_ahi), .cap_attr_o(c_attr),
      .cap_cmd_o(c_cmd), .cap_par_o(c_par), .irq_o(irq));

   // behavioural reference
   logic [N-1:0] m_cause, m_mask;
   logic [31:0]  m_alo, m_ahi, m_attr, m_cmd;
   logic [7:0]   m_par;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cause = '0; m_mask = '0;
         m_alo = '0; m_ahi = '0; m_attr = '0; m_cmd = '0; m_par = '0;
      end else begin
         logic [N-1:0] v, nc;
         v  = err_pulse & IMPL;
         nc = m_cause;
         if (we && !sel) nc = nc & wdata;
         nc = nc | v;
         if (v != '0 && m_cause == '0) begin
            m_alo = a_lo; m_ahi = a_hi; m_attr = attr; m_cmd = cmd; m_par = par;
         end
         if (we && sel) m_mask = wdata;
         m_cause = nc;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 cause", 64'(cause_o), 64'(m_cause));
      chk("R7 mask", 64'(mask_o), 64'(m_mask));
      chk("R4 cap_addr_lo", 64'(c_alo), 64'(m_alo));
      chk("R4 cap_addr_hi", 64'(c_ahi), 64'(m_ahi));
      chk("R4 cap_attr", 64'(c_attr), 64'(m_attr));
      chk("R4 cap_cmd", 64'(c_cmd), 64'(m_cmd));
      chk("R4 cap_par", 64'(c_par), 64'(m_par));
      chk("R8 irq", 64'(irq), 64'(|(m_cause & m_mask)));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_all();
      err_pulse = '0; we = 1'b0; sel = 1'b0; wdata = '0;
   endtask

   task automatic txn(input logic [31:0] base);
      a_lo = base; a_hi = base ^ 32'hFFFF_0000; attr = base + 32'h11;
      cmd = base + 32'h22; par = base[7:0] ^ 8'h5A;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; err_pulse = '0; we = 1'b0; sel = 1'b0; wdata = '0;
      txn(32'h0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 cause", 64'(cause_o), 64'h0);
      chk("R1 mask", 64'(mask_o), 64'h0);
      chk("R1 cap", 64'(c_alo | c_ahi | c_attr | c_cmd), 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);

      // first error, bit 1
      txn(32'hA000_0100); err_pulse = 8'h02; tick();
      chk("R4 first capture", 64'(c_alo), 64'hA000_0100);
      chk("R8 masked off", 64'(irq), 64'h0);

      // enable bit 1
      we = 1'b1; sel = 1'b1; wdata = 8'h02; tick();
      chk("R8 irq on", 64'(irq), 64'h1);

      // second error while pending
      txn(32'hB000_0200); err_pulse = 8'h08; tick();
      chk("R5 hold", 64'(c_alo), 64'hA000_0100);
      chk("R2 both set", 64'(cause_o), 64'h0A);

      // clear bit 1 with inverse write
      we = 1'b1; sel = 1'b0; wdata = 8'hFD; tick();
      chk("R2 cleared only bit1", 64'(cause_o), 64'h08);
      chk("R8 irq off", 64'(irq), 64'h0);

      // collision: pulse bit1 while clearing bit1 and bit3
      txn(32'hC000_0300); err_pulse = 8'h02; we = 1'b1; sel = 1'b0; wdata = 8'hF5; tick();
      chk("R3 error beats clear", 64'(cause_o), 64'h02);
      chk("R5 no capture while pending", 64'(c_alo), 64'hA000_0100);

      // absent bit 4
      err_pulse = 8'h10; tick();
      chk("R9 absent bit", 64'(cause_o), 64'h02);

      // clear all, then absent bit alone, then real error
      we = 1'b1; sel = 1'b0; wdata = 8'h00; tick();
      chk("R2 all clear", 64'(cause_o), 64'h0);
      txn(32'hD000_0400); err_pulse = 8'h10; tick();
      chk("R9 absent no capture", 64'(c_alo), 64'hA000_0100);
      txn(32'hE000_0500); err_pulse = 8'h40; tick();
      chk("R6 recapture", 64'(c_alo), 64'hE000_0500);
      chk("R6 recapture cmd", 64'(c_cmd), 64'hE000_0522);

      // mask zero then enable: cause untouched
      we = 1'b1; sel = 1'b1; wdata = 8'h00; tick();
      chk("R7 cause kept", 64'(cause_o), 64'h40);
      chk("R8 irq low during setup", 64'(irq), 64'h0);
      we = 1'b1; sel = 1'b1; wdata = 8'hFE; tick();
      chk("R7 mask loaded", 64'(mask_o), 64'hFE);
      chk("R8 irq high", 64'(irq), 64'h1);

      // random phase
      for (int k = 0; k < 400; k++) begin
         txn($urandom);
         if (($urandom % 4) == 0) err_pulse = N'($urandom) & N'($urandom);
         if (($urandom % 3) == 0) begin
            we = 1'b1; sel = 1'($urandom % 4 == 0); wdata = N'($urandom);
         end
         tick();
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule